// File: doc/BRIEF.md
# Keyed Watchdog Reset Timer

This block is a supervision timer for embedded software. A free-running count advances on every clock while the watchdog is active. If software does not prove it is alive before the count reaches the selected timeout, the block drives a system reset pulse of fixed length. The timeout is the base period scaled by a factor that a two-bit rate code selects.

A single strobe does not service the timer. Software must write two byte values, in order, to one service register. The first value arms the clearing logic. The second value clears the count and starts a new timeout period. If any other value is written between them, the sequence is abandoned. A disable input holds the whole timer idle. This input is meant to come from a non-volatile configuration bit that lives outside the block.

Top module: `keyed_watchdog`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `sys_rst` is 0, the key sequence is disarmed and the count is zero. The first timeout expires the full period after reset is released.
- R2: Two service writes clear the count, so `sys_rst` rises exactly L cycles after the clearing clock edge: first a write of 0x55, then a write of 0xAA. Here L is the current timeout.
- R3: A write of 0xAA while the sequence is not armed has no effect on the count or the timeout. A write of 0xAA that clears the count also disarms the sequence.
- R4: A write of any value other than 0x55 or 0xAA disarms the sequence. Repeated writes of 0x55 keep it armed.
- R5: The timeout L is BASE_TICKS × 1, 4, 16 or 64 for `rate_sel` codes 0, 1, 2 and 3. `sys_rst` rises on the L-th clock edge after the count was last zeroed.
- R6: While `wd_off` is 1, `sys_rst` never rises and the count stays at zero. After `wd_off` returns to 0, a full period elapses before the next timeout.
- R7: Each timeout drives `sys_rst` high for exactly PULSE_CYCLES clock cycles.
- R8: The count stays at zero during the pulse. It restarts from zero when the pulse ends, so the next pulse begins L cycles after the previous one ends.
- R9: Service writes made while `sys_rst` is high are ignored, and they leave the sequence disarmed.
- R10: Suppose `rate_sel` is changed to a timeout that the current count already meets or exceeds. The timeout then fires on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wd_off | input | 1 | 1 = watchdog held idle (disabled) |
| rate_sel | input | 2 | Timeout scale code: 0..3 → ×1, ×4, ×16, ×64 |
| svc_we | input | 1 | Write strobe for the service register |
| svc_data | input | 8 | Byte written to the service register |
| sys_rst | output | 1 | System reset pulse, active high |

## Verification
The hardest cases to reach are the ones that depend on key state surviving across events the software cannot see. One is an arm write that lands inside a reset pulse, followed by a clear write just after the pulse. Another is a rate code lowered below a count that has already advanced far. Directed sequences place writes on exact cycles relative to the pulse edges and to the rate change, and each one measures the cycle distance to the next rising edge of `sys_rst`. A long random phase then biases writes toward the two key values. It toggles the rate and the disable input rarely, and it compares every cycle against a bench-side cycle model.

// File: rtl/wdg_pkg.sv
// Package: shared types for the keyed watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package wdg_pkg;

    // State of the two-step service key.
    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    // Timeout scale code, as presented on the rate select input.
    typedef enum logic [1:0] {
        RATE_X1  = 2'd0,
        RATE_X4  = 2'd1,
        RATE_X16 = 2'd2,
        RATE_X64 = 2'd3
    } rate_e;

endpackage

// File: rtl/wdg_keyseq.sv
// Module: wdg_keyseq
// Tracks the ordered service key. An arm value moves the state to ARMED.
// A clear value while ARMED produces a one-cycle clear request and disarms.
// Any other value disarms.
// Assumes: hold is high while the reset pulse is active; writes are then ignored.
module wdg_keyseq
    import wdg_pkg::*;
#(
    parameter logic [7:0] ARM_KEY = 8'h55,
    parameter logic [7:0] CLR_KEY = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       we,
    input  logic [7:0] data,
    output logic       clr,
    output key_state_e state
);

    logic hit_arm;
    logic hit_clr;

    // Decode the written byte against both key values.
    always_comb begin
        hit_arm = we && !hold && (data == ARM_KEY);
        hit_clr = we && !hold && (data == CLR_KEY);
    end

    // Clear request: only a clear value that finds the sequence armed.
    always_comb clr = hit_clr && (state == KEY_ARMED);

    // Key state update: arm on the arm value, drop on anything else written or in hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= KEY_IDLE;
        end else if (hold) begin
            state <= KEY_IDLE;
        end else if (we) begin
            state <= hit_arm ? KEY_ARMED : KEY_IDLE;
        end
    end

    assert_arm_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_arm |=> state == KEY_ARMED);

    assert_clear_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> state == KEY_IDLE);

    assert_hold_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> state == KEY_IDLE);

endmodule

// File: rtl/wdg_timeout.sv
// Module: wdg_timeout
// Counts clocks toward the timeout picked by the rate code. It raises expire
// for one cycle when the count meets the threshold (L-1). The count zeroes on
// expire, clear, hold and disable.
// Assumes: BASE_TICKS >= 1 and CW wide enough for BASE_TICKS*64.
module wdg_timeout
    import wdg_pkg::*;
#(
    parameter int BASE_TICKS = 1024,
    parameter int CW         = $clog2(BASE_TICKS * 64 + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          off,
    input  logic          hold,
    input  logic          clr,
    input  logic [1:0]    rate,
    output logic          expire,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] THR_X1  = CW'(BASE_TICKS * 1  - 1);
    localparam logic [CW-1:0] THR_X4  = CW'(BASE_TICKS * 4  - 1);
    localparam logic [CW-1:0] THR_X16 = CW'(BASE_TICKS * 16 - 1);
    localparam logic [CW-1:0] THR_X64 = CW'(BASE_TICKS * 64 - 1);

    logic [CW-1:0] thr;

    // Select the expiry threshold for the current rate code.
    always_comb begin
        unique case (rate_e'(rate))
            RATE_X1:  thr = THR_X1;
            RATE_X4:  thr = THR_X4;
            RATE_X16: thr = THR_X16;
            default:  thr = THR_X64;
        endcase
    end

    // Expiry: active, not serviced this cycle, and count at or past threshold.
    always_comb expire = !off && !hold && !clr && (count >= thr);

    // Timeout count: zero on any restart cause, otherwise advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (off || hold || clr || expire) begin
            count <= '0;
        end else begin
            count <= count + CW'(1);
        end
    end

    assert_off_holds_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> count == '0);

    assert_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= THR_X64);

    assert_expire_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> count == '0);

endmodule

// File: rtl/wdg_pulse.sv
// Module: wdg_pulse
// Stretches a one-cycle start into a reset pulse exactly PULSE_CYCLES long.
// Assumes: start is never raised while busy (the parent holds the timer).
module wdg_pulse #(
    parameter int PULSE_CYCLES = 16,
    parameter int PW           = $clog2(PULSE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    logic [PW-1:0] left;

    // Remaining pulse cycles: load on start, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
        end else if (start && left == '0) begin
            left <= PW'(PULSE_CYCLES);
        end else if (left != '0) begin
            left <= left - PW'(1);
        end
    end

    // Pulse is high while cycles remain.
    always_comb busy = (left != '0);

    assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);

    assert_load_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> left == PW'(PULSE_CYCLES));

    assert_left_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        left <= PW'(PULSE_CYCLES));

endmodule

// File: rtl/keyed_watchdog.sv
// Module: keyed_watchdog (top)
// Watchdog that issues a fixed-length reset pulse unless serviced with an
// arm value followed by a clear value before the selected timeout.
// Assumes: wd_off is static configuration or changes rarely; synchronous reset.
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int         BASE_TICKS   = 1024,
    parameter int         PULSE_CYCLES = 16,
    parameter logic [7:0] ARM_KEY      = 8'h55,
    parameter logic [7:0] CLR_KEY      = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wd_off,
    input  logic [1:0] rate_sel,
    input  logic       svc_we,
    input  logic [7:0] svc_data,
    output logic       sys_rst
);

    localparam int CW = $clog2(BASE_TICKS * 64 + 1);
    localparam int PW = $clog2(PULSE_CYCLES + 1);

    logic          clr;
    logic          expire;
    logic          busy;
    logic [CW-1:0] count;
    key_state_e    kstate;

    wdg_keyseq #(
        .ARM_KEY (ARM_KEY),
        .CLR_KEY (CLR_KEY)
    ) u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (busy),
        .we    (svc_we),
        .data  (svc_data),
        .clr   (clr),
        .state (kstate)
    );

    wdg_timeout #(
        .BASE_TICKS (BASE_TICKS),
        .CW         (CW)
    ) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .off    (wd_off),
        .hold   (busy),
        .clr    (clr),
        .rate   (rate_sel),
        .expire (expire),
        .count  (count)
    );

    wdg_pulse #(
        .PULSE_CYCLES (PULSE_CYCLES),
        .PW           (PW)
    ) u_pls (
        .clk   (clk),
        .rst_n (rst_n),
        .start (expire),
        .busy  (busy)
    );

    // Drive the reset output from the pulse stretcher.
    always_comb sys_rst = busy;

    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_off && !sys_rst) |=> !sys_rst);

    assert_restart_after_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> count == '0);

    assert_service_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wd_off) |=> (count == '0 && kstate == KEY_IDLE));

    assert_rise_needs_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> $past(expire));

endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;

    localparam int BASE = 8;
    localparam int PLEN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wd_off = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       svc_we = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       sys_rst;

    int checks = 0;
    int fails  = 0;

    keyed_watchdog #(
        .BASE_TICKS   (BASE),
        .PULSE_CYCLES (PLEN)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wd_off   (wd_off),
        .rate_sel (rate_sel),
        .svc_we   (svc_we),
        .svc_data (svc_data),
        .sys_rst  (sys_rst)
    );

    always #2 clk = ~clk;

    function automatic int tmo(input int code);
        return BASE << (2 * code);
    endfunction

    // Cycle model built from the requirements.
    int m_cnt = 0;
    int m_left = 0;
    bit m_arm = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_left = 0; m_arm = 0;
        end else begin
            bit b, c, e;
            b = (m_left != 0);
            c = svc_we && svc_data == 8'hAA && m_arm && !b;
            e = !wd_off && !b && !c && (m_cnt >= tmo(int'(rate_sel)) - 1);
            if (b) m_arm = 0;
            else if (svc_we) m_arm = (svc_data == 8'h55);
            if (wd_off || b || c || e) m_cnt = 0; else m_cnt = m_cnt + 1;
            if (e) m_left = PLEN; else if (m_left != 0) m_left = m_left - 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(input int code, input bit off);
        @(negedge clk);
        rst_n = 1'b0; svc_we = 1'b0; rate_sel = 2'(code); wd_off = off;
        repeat (3) @(negedge clk);
        chk("R1 output low in reset", int'(sys_rst), 0);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] d);
        svc_we = 1'b1; svc_data = d;
        @(negedge clk);
        svc_we = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (!sys_rst && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 2000) n = -1;
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (sys_rst && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: run hung, actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int hi;
        void'($urandom(32'd4711));

        // R1 and R5: first timeout after reset at rate 0
        do_reset(0, 0);
        chk("R1 output low after release", int'(sys_rst), 0);
        measure(n);
        chk("R1 full period after reset", n, tmo(0));
        pulse_len(n);
        chk("R7 pulse length", n, PLEN);
        measure(n);
        chk("R8 period after pulse end", n, tmo(0));

        // R5: every rate code
        for (int r = 0; r < 4; r++) begin
            do_reset(r, 0);
            measure(n);
            chk("R5 timeout per rate code", n, tmo(r));
        end
        pulse_len(n);
        chk("R7 pulse length at rate 3", n, PLEN);

        // R2: arm then clear mid-period
        do_reset(1, 0);
        repeat (20) @(negedge clk);
        wr(8'h55); wr(8'hAA);
        measure(n);
        chk("R2 service restarts period", n, tmo(1));

        // R3: clear value without arm
        do_reset(1, 0);
        repeat (10) @(negedge clk);
        wr(8'hAA);
        measure(n);
        chk("R3 unarmed clear ignored", n, tmo(1) - 11);

        // R3: second clear after a good service does nothing
        do_reset(1, 0);
        repeat (5) @(negedge clk);
        wr(8'h55); wr(8'hAA);
        repeat (10) @(negedge clk);
        wr(8'hAA);
        measure(n);
        chk("R3 repeated clear ignored", n, tmo(1) - 11);

        // R4: foreign byte disarms
        do_reset(1, 0);
        repeat (5) @(negedge clk);
        wr(8'h55); wr(8'h12); wr(8'hAA);
        measure(n);
        chk("R4 other value disarms", n, tmo(1) - 8);

        // R4: repeated arm stays armed
        do_reset(1, 0);
        repeat (5) @(negedge clk);
        wr(8'h55); wr(8'h55); wr(8'hAA);
        measure(n);
        chk("R4 double arm still clears", n, tmo(1));

        // R6: disabled watchdog stays quiet
        do_reset(0, 1);
        hi = 0;
        repeat (100) begin
            @(negedge clk);
            if (sys_rst) hi = 1;
        end
        chk("R6 no pulse while off", hi, 0);
        wd_off = 1'b0;
        measure(n);
        chk("R6 full period after enable", n, tmo(0));

        // R9: arm inside pulse is dropped
        do_reset(0, 0);
        measure(n);
        wr(8'h55);
        while (sys_rst) @(negedge clk);
        wr(8'hAA);
        measure(n);
        chk("R9 write during pulse ignored", n, tmo(0) - 1);

        // R10: lowering the rate below the count fires at once
        do_reset(3, 0);
        repeat (50) @(negedge clk);
        rate_sel = 2'd0;
        measure(n);
        chk("R10 rate drop fires next edge", n, 1);

        // Random phase against the cycle model (R2/R5/R7)
        do_reset(0, 0);
        for (int i = 0; i < 6000; i++) begin
            int r;
            @(negedge clk);
            chk("R5/R7 model compare", int'(sys_rst), int'(m_left != 0));
            r = int'($urandom % 100);
            svc_we = (r < 30);
            r = int'($urandom % 10);
            svc_data = (r < 4) ? 8'h55 : (r < 8) ? 8'hAA : 8'($urandom);
            if ($urandom % 100 == 0) rate_sel = 2'($urandom % 2);
            if ($urandom % 400 == 0) wd_off = ~wd_off;
        end
        svc_we = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule